// File: doc/BRIEF.md
# I/Q Sample Serial Streamer

This block sends offset-corrected I and Q receive samples out of a serial port without any register traffic. Once the receive path reports ready, it transmits one I/Q pair in every 48-cycle slot of the master clock. Each sample goes out as its own 16-bit word: the 15-bit two's-complement sample first, MSB first, followed by a channel flag in the last bit. Every word is announced by its own one-cycle frame-sync pulse.

Two serial ports share the block. A select bit, captured at each slot boundary, decides which one carries the samples. The other port stays quiet and keeps its own programmed bit-clock rate. The serial clock is modelled as a per-port bit-clock strobe. While a port streams, its strobe is forced to every master-clock cycle whatever rate it is programmed to. Otherwise it pulses at the programmed divided rate. The output-enable of each port is high only while that port drives word bits, which lets a pad release the line at all other times.

Top module: `iq_stream_tx`

## Requirements
- R1: While reset is high, every port output (strobe, data, frame sync, enable) is low.
- R2: A word carries the sample in bits 15..1, MSB first, and a flag in bit 0: 0 for an I word, 1 for a Q word.
- R3: Each word is 16 data cycles long. The enable is high during exactly those cycles. The one-cycle frame sync falls in the cycle just before the MSB. Data is low whenever the enable is low.
- R4: In every pair the I word goes first, and the Q frame sync follows the I frame sync by 24 cycles. This leaves 8 cycles between the end of the I data and the Q MSB.
- R5: Slot boundaries fall every 48 cycles counted from the release of reset. At each boundary the select bit is captured: 0 routes the pair to port 0 and 1 routes it to port 1. The unselected port shows no frame sync, enable or data.
- R6: Samples and the ready flag are captured at a slot boundary. The I frame sync of a pair appears 1 cycle into its slot, so streaming begins in the first slot after ready is seen high.
- R7: Dropping ready at any point in a slot lets the pair already captured finish both words. After that, no further frame sync appears.
- R8: While a port streams, its bit-clock strobe is high in every cycle, whatever its rate input holds.
- R9: A port that is not streaming pulses its strobe once every 2×rate cycles; a rate of 0 gives a strobe every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_ready | input | 1 | Receive path ready; sampled at slot boundaries |
| i_sample | input | 15 | Corrected I sample, two's complement |
| q_sample | input | 15 | Corrected Q sample, two's complement |
| port_sel | input | 1 | Destination port: 0 = port 0, 1 = port 1 |
| p0_rate | input | 10 | Port 0 idle bit-clock divider setting |
| p1_rate | input | 10 | Port 1 idle bit-clock divider setting |
| p0_sck | output | 1 | Port 0 bit-clock strobe |
| p0_sd | output | 1 | Port 0 serial data |
| p0_fs | output | 1 | Port 0 frame sync |
| p0_oe | output | 1 | Port 0 output enable |
| p1_sck | output | 1 | Port 1 bit-clock strobe |
| p1_sd | output | 1 | Port 1 serial data |
| p1_fs | output | 1 | Port 1 frame sync |
| p1_oe | output | 1 | Port 1 output enable |

## Verification
The assertions assume that the ready flag and the select bit matter only at slot boundaries, and that the sample inputs are stable at the boundary edge. Under that assumption, a frame sync is always followed by a full 16-cycle word on the same port, and never on both ports at once. The stimulus changes samples, select and ready only at slot position 30 or 10, well away from the capture edge. It moves the select bit mid-pair only to show that the change waits for the next boundary.

// File: rtl/iqs_pkg.sv
package iqs_pkg;
  typedef enum logic {
    PORT_PRI = 1'b0,
    PORT_AUX = 1'b1
  } port_e;

  localparam int NUM_PORTS = 2;
endpackage

// File: rtl/iqs_slot_seq.sv
module iqs_slot_seq #(
  parameter int SLOT_LEN = 48,
  parameter int WORD_W   = 16,
  parameter int GAP      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic                         slot_end,
  output logic                         fs_hit,
  output logic                         bit_hit,
  output logic                         q_half,
  output logic [$clog2(WORD_W)-1:0]    bit_idx
);
  localparam int CNT_W = $clog2(SLOT_LEN);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(SLOT_LEN - 1);
  localparam logic [CNT_W-1:0] I_FS   = '0;
  localparam logic [CNT_W-1:0] I_END  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] Q_FS   = CNT_W'(WORD_W + GAP);
  localparam logic [CNT_W-1:0] Q_END  = CNT_W'(WORD_W + GAP + WORD_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] diff;
  logic             i_rng;
  logic             q_rng;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    i_rng    = (cnt > I_FS) && (cnt <= I_END);
    q_rng    = (cnt > Q_FS) && (cnt <= Q_END);
    slot_end = (cnt == LAST);
    fs_hit   = (cnt == I_FS) || (cnt == Q_FS);
    bit_hit  = i_rng || q_rng;
    q_half   = q_rng;
    diff     = q_rng ? (Q_END - cnt) : (I_END - cnt);
    bit_idx  = diff[IDX_W-1:0];
  end
endmodule

// File: rtl/iqs_port_out.sv
module iqs_port_out #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             fs_hit,
  input  logic             bit_hit,
  input  logic             bit_val,
  input  logic [DIV_W-1:0] rate,
  output logic             sck,
  output logic             sd,
  output logic             fs,
  output logic             oe
);
  localparam int LIM_W = DIV_W + 1;

  logic [LIM_W-1:0] div_cnt;
  logic [LIM_W-1:0] lim;

  assign lim = {rate, 1'b0} - LIM_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fs <= 1'b0;
      oe <= 1'b0;
      sd <= 1'b0;
    end else begin
      fs <= enable && fs_hit;
      oe <= enable && bit_hit;
      sd <= enable && bit_hit && bit_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      sck     <= 1'b0;
    end else if (enable || (rate == '0) || (div_cnt >= lim)) begin
      div_cnt <= '0;
      sck     <= 1'b1;
    end else begin
      div_cnt <= div_cnt + LIM_W'(1);
      sck     <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_stream_tx.sv
module iq_stream_tx
  import iqs_pkg::*;
#(
  parameter int SAMPLE_W = 15,
  parameter int SLOT_LEN = 48,
  parameter int GAP      = 8,
  parameter int DIV_W    = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_ready,
  input  logic [SAMPLE_W-1:0] i_sample,
  input  logic [SAMPLE_W-1:0] q_sample,
  input  logic                port_sel,
  input  logic [DIV_W-1:0]    p0_rate,
  input  logic [DIV_W-1:0]    p1_rate,
  output logic                p0_sck,
  output logic                p0_sd,
  output logic                p0_fs,
  output logic                p0_oe,
  output logic                p1_sck,
  output logic                p1_sd,
  output logic                p1_fs,
  output logic                p1_oe
);
  localparam int WORD_W = SAMPLE_W + 1;
  localparam int IDX_W  = $clog2(WORD_W);

  logic              slot_end;
  logic              fs_hit;
  logic              bit_hit;
  logic              q_half;
  logic [IDX_W-1:0]  bit_idx;
  logic              active;
  port_e             sel_q;
  logic [WORD_W-1:0] word_i;
  logic [WORD_W-1:0] word_q;
  logic              cur_bit;

  logic [DIV_W-1:0]  rate_arr [NUM_PORTS];
  logic              sck_arr  [NUM_PORTS];
  logic              sd_arr   [NUM_PORTS];
  logic              fs_arr   [NUM_PORTS];
  logic              oe_arr   [NUM_PORTS];

  iqs_slot_seq #(
    .SLOT_LEN (SLOT_LEN),
    .WORD_W   (WORD_W),
    .GAP      (GAP)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .slot_end (slot_end),
    .fs_hit   (fs_hit),
    .bit_hit  (bit_hit),
    .q_half   (q_half),
    .bit_idx  (bit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sel_q  <= PORT_PRI;
      word_i <= '0;
      word_q <= '0;
    end else if (slot_end) begin
      active <= rx_ready;
      sel_q  <= port_e'(port_sel);
      word_i <= {i_sample, 1'b0};
      word_q <= {q_sample, 1'b1};
    end
  end

  assign cur_bit     = q_half ? word_q[bit_idx] : word_i[bit_idx];
  assign rate_arr[0] = p0_rate;
  assign rate_arr[1] = p1_rate;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic here;
    assign here = active && (sel_q == port_e'(g));

    iqs_port_out #(
      .DIV_W (DIV_W)
    ) u_out (
      .clk     (clk),
      .rst     (rst),
      .enable  (here),
      .fs_hit  (fs_hit),
      .bit_hit (bit_hit),
      .bit_val (cur_bit),
      .rate    (rate_arr[g]),
      .sck     (sck_arr[g]),
      .sd      (sd_arr[g]),
      .fs      (fs_arr[g]),
      .oe      (oe_arr[g])
    );
  end

  assign p0_sck = sck_arr[0];
  assign p0_sd  = sd_arr[0];
  assign p0_fs  = fs_arr[0];
  assign p0_oe  = oe_arr[0];
  assign p1_sck = sck_arr[1];
  assign p1_sd  = sd_arr[1];
  assign p1_fs  = fs_arr[1];
  assign p1_oe  = oe_arr[1];
endmodule

// File: rtl/iqs_checker.sv
module iqs_checker #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst,
  input logic p0_sck,
  input logic p0_sd,
  input logic p0_fs,
  input logic p0_oe,
  input logic p1_sck,
  input logic p1_sd,
  input logic p1_fs,
  input logic p1_oe
);
  localparam int RUN_W = $clog2(WORD_W + 1) + 1;

  logic [RUN_W-1:0] run0;
  logic [RUN_W-1:0] run1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run0 <= '0;
      run1 <= '0;
    end else begin
      run0 <= p0_oe ? run0 + RUN_W'(1) : '0;
      run1 <= p1_oe ? run1 + RUN_W'(1) : '0;
    end
  end

  AST_FS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({p0_fs, p1_fs})); // R5
  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({p0_oe, p1_oe})); // R5
  AST_P0_FS_LEADS: assert property (@(posedge clk) disable iff (rst) p0_fs |=> p0_oe); // R3
  AST_P1_FS_LEADS: assert property (@(posedge clk) disable iff (rst) p1_fs |=> p1_oe); // R3
  AST_P0_WORD_LEN: assert property (@(posedge clk) disable iff (rst) p0_oe |-> (run0 < RUN_W'(WORD_W))); // R3
  AST_P1_WORD_LEN: assert property (@(posedge clk) disable iff (rst) p1_oe |-> (run1 < RUN_W'(WORD_W))); // R3
  AST_P0_QUIET: assert property (@(posedge clk) disable iff (rst) !p0_oe |-> !p0_sd); // R3
  AST_P1_QUIET: assert property (@(posedge clk) disable iff (rst) !p1_oe |-> !p1_sd); // R3
  AST_P0_FULL_RATE: assert property (@(posedge clk) disable iff (rst) p0_oe |-> p0_sck); // R8
  AST_P1_FULL_RATE: assert property (@(posedge clk) disable iff (rst) p1_oe |-> p1_sck); // R8
endmodule

bind iq_stream_tx iqs_checker #(.WORD_W(SAMPLE_W + 1)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .p0_sck (p0_sck),
  .p0_sd  (p0_sd),
  .p0_fs  (p0_fs),
  .p0_oe  (p0_oe),
  .p1_sck (p1_sck),
  .p1_sd  (p1_sd),
  .p1_fs  (p1_fs),
  .p1_oe  (p1_oe)
);

// File: tb/iq_stream_tx_bench.sv
module iq_stream_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_ready = 1'b0;
  logic [14:0] i_sample = '0;
  logic [14:0] q_sample = '0;
  logic        port_sel = 1'b0;
  logic [9:0]  p0_rate = 10'd4;
  logic [9:0]  p1_rate = 10'd0;
  logic p0_sck, p0_sd, p0_fs, p0_oe, p1_sck, p1_sd, p1_fs, p1_oe;

  int checks = 0;
  int errors = 0;
  int e = 0;
  int mark = 0;
  int fs_seen = 0;
  logic [16:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_stream_tx u_iq_stream_tx (
    .clk(clk), .rst(rst), .rx_ready(rx_ready), .i_sample(i_sample), .q_sample(q_sample),
    .port_sel(port_sel), .p0_rate(p0_rate), .p1_rate(p1_rate),
    .p0_sck(p0_sck), .p0_sd(p0_sd), .p0_fs(p0_fs), .p0_oe(p0_oe),
    .p1_sck(p1_sck), .p1_sd(p1_sd), .p1_fs(p1_fs), .p1_oe(p1_oe)
  );

  always @(posedge clk) begin
    if (rst) e <= 0;
    else e <= e + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_pos(input int p);
    while ((e % SLOT) != p) @(negedge clk);
  endtask

  task automatic start_pairs(input logic [14:0] iv, input logic [14:0] qv, input logic sel, input int n);
    wait_pos(30);
    i_sample = iv; q_sample = qv; port_sel = sel; rx_ready = 1'b1;
    mark = e;
    for (int k = 0; k < n; k++) begin
      expq.push_back({sel, iv, 1'b0});
      expq.push_back({sel, qv, 1'b1});
    end
  endtask

  task automatic run_pairs(input logic [14:0] iv, input logic [14:0] qv, input logic sel, input int n);
    start_pairs(iv, qv, sel, n);
    while (e < mark + n * SLOT) @(negedge clk);
  endtask

  // Scoreboard monitor
  int          coll [2] = '{0, 0};
  logic [15:0] sh   [2];
  int          fs_e [2] = '{0, 0};
  int          last_i = 0;

  always @(negedge clk) begin
    logic fsv [2], oev [2], sdv [2], sckv [2];
    logic [16:0] exp_item;
    fsv = '{p0_fs, p1_fs}; oev = '{p0_oe, p1_oe}; sdv = '{p0_sd, p1_sd}; sckv = '{p0_sck, p1_sck};
    if (!rst) begin
      if (p0_fs && p1_fs) chk(1'b0, "R5 fs on both ports", 3, 1);
      for (int p = 0; p < 2; p++) begin
        if (coll[p] > 0) begin
          if (!oev[p]) chk(1'b0, "R3 enable low in word", 0, 1);
          if (!sckv[p]) chk(1'b0, "R8 strobe low while streaming", 0, 1);
          sh[p] = {sh[p][14:0], sdv[p]};
          coll[p]--;
          if (coll[p] == 0) begin
            if (expq.size() == 0) begin
              chk(1'b0, "R7 unexpected word", int'(sh[p]), 0);
            end else begin
              exp_item = expq.pop_front();
              chk(exp_item[16] == 1'(p), "R5 port", p, int'(exp_item[16]));
              chk(sh[p] == exp_item[15:0], "R2 word", int'(sh[p]), int'(exp_item[15:0]));
              if (!exp_item[0]) begin
                chk((fs_e[p] % SLOT) == 1, "R6 I frame position", fs_e[p] % SLOT, 1);
                last_i = fs_e[p];
              end else begin
                chk(fs_e[p] - last_i == 24, "R4 Q after I", fs_e[p] - last_i, 24);
              end
            end
          end
        end else if (oev[p]) begin
          chk(1'b0, "R3 stray enable", 1, 0);
        end
        if (fsv[p]) begin
          fs_seen++;
          if (coll[p] > 0) chk(1'b0, "R3 frame sync inside word", coll[p], 0);
          coll[p] = 16;
          fs_e[p] = e;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0, c1, snap;
    repeat (4) @(negedge clk);
    // R1: quiet during reset
    chk({p0_sck, p0_sd, p0_fs, p0_oe, p1_sck, p1_sd, p1_fs, p1_oe} == 8'h00, "R1 reset outputs",
        int'({p0_sck, p0_sd, p0_fs, p0_oe, p1_sck, p1_sd, p1_fs, p1_oe}), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    // R9: idle strobe rate
    c0 = 0; c1 = 0;
    for (int k = 0; k < 96; k++) begin
      c0 += int'(p0_sck); c1 += int'(p1_sck);
      @(negedge clk);
    end
    chk(c0 == 12, "R9 port0 rate 4", c0, 12);
    chk(c1 == 96, "R9 port1 rate 0", c1, 96);

    // R8: forced full rate while streaming, other port keeps its rate
    p0_rate = 10'd5; p1_rate = 10'd3;
    start_pairs(15'h1A5C, 15'h4321, 1'b0, 4);
    wait_pos(2);
    c0 = 0; c1 = 0;
    for (int k = 0; k < 96; k++) begin
      if (k < 48) c0 += int'(p0_sck);
      c1 += int'(p1_sck);
      @(negedge clk);
    end
    chk(c0 == 48, "R8 port0 strobe every cycle", c0, 48);
    chk(c1 == 16, "R9 idle port1 rate 3", c1, 16);
    while (e < mark + 4 * SLOT) @(negedge clk);

    run_pairs(15'h3FFF, 15'h4000, 1'b1, 3);
    run_pairs(15'h7FFF, 15'h0000, 1'b0, 2);
    run_pairs(15'h5555, 15'h2AAA, 1'b1, 1);

    // R7: stop after Q frame sync already issued
    wait_pos(30);
    rx_ready = 1'b0;
    snap = fs_seen;
    repeat (150) @(negedge clk);
    chk(fs_seen == snap, "R7 no frame after stop", fs_seen - snap, 0);
    chk(expq.size() == 0, "R7 pairs drained", expq.size(), 0);

    // R7/R5: stop in the middle of the I word, select and samples change too
    start_pairs(15'h0F0F, 15'h7001, 1'b0, 1);
    snap = fs_seen;
    @(negedge clk);
    wait_pos(10);
    rx_ready = 1'b0; port_sel = 1'b1; i_sample = 15'h0000; q_sample = 15'h0000;
    repeat (150) @(negedge clk);
    chk(fs_seen - snap == 2, "R7 captured pair completes", fs_seen - snap, 2);
    chk(expq.size() == 0, "R7 queue empty", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule